// File: doc/BRIEF.md
# Orthogonal Opcode Field Decoder

This block decodes single opcode bytes for a compact 8-bit instruction set. In that set, the operation group, the registers and the branch condition each sit in a 3-bit field aligned to octal digits. For each opcode byte presented with `op_valid`, the block produces the following, all registered and one cycle later:

- an instruction class;
- the source register, destination register, ALU operation and condition code that the class uses;
- the total instruction length in bytes, so a fetch unit knows whether one immediate byte or a two-byte address (low byte first) follows;
- a flag marking an operand that lives in memory at the address held in the H:L register pair;
- an evaluation of the branch condition against a 4-bit flag input.

Register field value 7 names the memory operand rather than a physical register. A few fixed byte values override the regular field pattern: three halt codes and one no-op. Any byte that matches no defined pattern is reported as illegal and is passed on as a no-op. Execution, the I/O opcodes and the behaviour of the two rotate opcodes are outside this block; the rotates are only classified.

Top module: `opcode_field_decoder`

## Requirements
- R1: While `rst_n` is low and after its release until the first accepted opcode, `dec_valid` is 0 and every decoded output is 0.
- R2: An opcode accepted with `op_valid` high at a clock edge appears decoded after that edge with `dec_valid` high. With `op_valid` low, `dec_valid` drops to 0 after the next edge and all decoded outputs keep their previous values.
- R3: Opcodes 0x00, 0x01 and 0xFF decode as class 1 (halt), length 1, with all other fields 0. This holds even though 0xFF also fits the move pattern.
- R4: Opcode 0xC0 decodes as class 0 (no-op), length 1, `illegal` 0, all fields 0.
- R5: Any other opcode of form 11DDDSSS decodes as class 2 (move), with `dst_reg`=DDD, `src_reg`=SSS and length 1.
- R6: Form 10AAASSS decodes as class 3 (ALU), with `alu_op`=AAA, `src_reg`=SSS and length 1.
- R7: `mem_operand` is 1 exactly in these cases: a move whose SSS or DDD is 7, an ALU operation whose SSS is 7, or a load-immediate whose DDD is 7. For every other opcode it is 0.
- R8: Form 00AAA100 decodes as class 4 (ALU immediate) with `alu_op`=AAA. Form 00DDD110 decodes as class 5 (load immediate) with `dst_reg`=DDD. Both have length 2.
- R9: Form 01CCC000 decodes as class 6 (jump) and form 01CCC010 as class 7 (call), each with `cond_code`=CCC. Forms 01xxx100 (jump) and 01xxx110 (call) are unconditional, with `cond_code` 0. All four forms have length 3.
- R10: Form 00CCC011 decodes as class 8 (return) with `cond_code`=CCC. Form 00xxx111 is an unconditional return with `cond_code` 0. Both have length 1.
- R11: For a conditional jump, call or return, `cond_met` equals the selected flag when CCC[2] is 1 and its inverse when CCC[2] is 0. CCC[1:0] selects `flags` bit 0 (carry), 1 (zero), 2 (sign) or 3 (parity). For an unconditional transfer `cond_met` is 1; for every other class it is 0.
- R12: Opcodes 0x02 and 0x0A decode as class 9 (rotate), length 1, with all fields 0.
- R13: Every opcode not covered by R3 to R12 decodes as class 0 with `illegal` 1, length 1 and all other fields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode byte present this cycle |
| opcode | input | 8 | Opcode byte |
| flags | input | 4 | Status flags: bit 0 carry, 1 zero, 2 sign, 3 parity |
| dec_valid | output | 1 | Decoded outputs belong to an opcode accepted at the last edge |
| dec_class | output | 4 | Instruction class code |
| src_reg | output | 3 | Source register field |
| dst_reg | output | 3 | Destination register field |
| alu_op | output | 3 | ALU operation field |
| cond_code | output | 3 | Branch condition field |
| inst_len | output | 2 | Total instruction length in bytes (1 to 3) |
| mem_operand | output | 1 | An operand is memory addressed by H:L |
| cond_met | output | 1 | Transfer is taken for the given flags |
| illegal | output | 1 | Opcode matches no defined pattern |

## Verification
Two functions can act on the same opcode in the same cycle: the fixed-code overrides and the regular field decode. 0xFF fits the move pattern with both register fields equal to 7, and 0xC0 fits it with both equal to 0. The bench applies these bytes, and the full set of 256 opcodes, under random flag values. The result is judged correct only if the override wins, with class halt or no-op, `mem_operand` 0 and no register fields. Condition evaluation is also swept across every condition code against all sixteen flag combinations, and the results are compared against an independent reference function.

// File: rtl/opcode_field_decoder.sv
module opcode_field_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [7:0] opcode,
  input  logic [3:0] flags,
  output logic       dec_valid,
  output logic [3:0] dec_class,
  output logic [2:0] src_reg,
  output logic [2:0] dst_reg,
  output logic [2:0] alu_op,
  output logic [2:0] cond_code,
  output logic [1:0] inst_len,
  output logic       mem_operand,
  output logic       cond_met,
  output logic       illegal
);
  localparam logic [3:0] CL_NOP  = 4'd0;
  localparam logic [3:0] CL_HALT = 4'd1;
  localparam logic [3:0] CL_MOVE = 4'd2;
  localparam logic [3:0] CL_ALU  = 4'd3;
  localparam logic [3:0] CL_ALUI = 4'd4;
  localparam logic [3:0] CL_LDI  = 4'd5;
  localparam logic [3:0] CL_JMP  = 4'd6;
  localparam logic [3:0] CL_CALL = 4'd7;
  localparam logic [3:0] CL_RET  = 4'd8;
  localparam logic [3:0] CL_ROT  = 4'd9;
  localparam logic [2:0] MEM_REG = 3'd7;

  wire [2:0] hi = opcode[5:3];
  wire [2:0] lo = opcode[2:0];
  wire       sel_flag = flags[hi[1:0]];
  wire       cond_true = hi[2] ? sel_flag : ~sel_flag;

  logic [3:0] n_class;
  logic [2:0] n_src, n_dst, n_alu, n_cond;
  logic [1:0] n_len;
  logic       n_mem, n_met, n_ill;

  always_comb begin
    n_class = CL_NOP;
    n_src = '0; n_dst = '0; n_alu = '0; n_cond = '0;
    n_len = 2'd1; n_mem = 1'b0; n_met = 1'b0; n_ill = 1'b0;
    if (opcode == 8'h00 || opcode == 8'h01 || opcode == 8'hFF) begin
      n_class = CL_HALT;
    end else if (opcode == 8'hC0) begin
      n_class = CL_NOP;
    end else begin
      case (opcode[7:6])
        2'b11: begin
          n_class = CL_MOVE; n_src = lo; n_dst = hi;
          n_mem = (lo == MEM_REG) || (hi == MEM_REG);
        end
        2'b10: begin
          n_class = CL_ALU; n_src = lo; n_alu = hi;
          n_mem = (lo == MEM_REG);
        end
        2'b01: begin
          n_len = 2'd3;
          case (lo)
            3'd0: begin n_class = CL_JMP;  n_cond = hi; n_met = cond_true; end
            3'd2: begin n_class = CL_CALL; n_cond = hi; n_met = cond_true; end
            3'd4: begin n_class = CL_JMP;  n_met = 1'b1; end
            3'd6: begin n_class = CL_CALL; n_met = 1'b1; end
            default: begin n_ill = 1'b1; n_len = 2'd1; end
          endcase
        end
        default: begin
          case (lo)
            3'd3: begin n_class = CL_RET; n_cond = hi; n_met = cond_true; end
            3'd7: begin n_class = CL_RET; n_met = 1'b1; end
            3'd4: begin n_class = CL_ALUI; n_alu = hi; n_len = 2'd2; end
            3'd6: begin
              n_class = CL_LDI; n_dst = hi; n_len = 2'd2;
              n_mem = (hi == MEM_REG);
            end
            3'd2: begin
              if (hi[2:1] == 2'b00) n_class = CL_ROT;
              else n_ill = 1'b1;
            end
            default: n_ill = 1'b1;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_class <= '0; src_reg <= '0; dst_reg <= '0; alu_op <= '0;
      cond_code <= '0; inst_len <= '0; mem_operand <= 1'b0;
      cond_met <= 1'b0; illegal <= 1'b0;
    end else begin
      dec_valid <= op_valid;
      if (op_valid) begin
        dec_class <= n_class; src_reg <= n_src; dst_reg <= n_dst;
        alu_op <= n_alu; cond_code <= n_cond; inst_len <= n_len;
        mem_operand <= n_mem; cond_met <= n_met; illegal <= n_ill;
      end
    end
  end
endmodule

// File: rtl/opcode_field_decoder_checks.sv
module opcode_field_decoder_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [7:0] opcode,
  input logic       dec_valid,
  input logic [3:0] dec_class,
  input logic [1:0] inst_len,
  input logic       mem_operand,
  input logic       cond_met,
  input logic       illegal
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> dec_valid);

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(dec_class) && $stable(inst_len) && !dec_valid));

  assert_halt_override_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 8'hFF) |=> (dec_class == 4'd1 && !mem_operand));

  assert_mem_classes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_operand |-> (dec_class == 4'd2 || dec_class == 4'd3 || dec_class == 4'd5));

  assert_transfer_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && (dec_class == 4'd6 || dec_class == 4'd7)) |-> inst_len == 2'd3);

  assert_met_only_transfer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cond_met |-> (dec_class >= 4'd6 && dec_class <= 4'd8));

  assert_illegal_as_nop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (dec_class == 4'd0 && inst_len == 2'd1 && !mem_operand));
endmodule

bind opcode_field_decoder opcode_field_decoder_checks u_checks (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
  .dec_valid(dec_valid), .dec_class(dec_class), .inst_len(inst_len),
  .mem_operand(mem_operand), .cond_met(cond_met), .illegal(illegal)
);

// File: tb/opcode_field_decoder_test.sv
module opcode_field_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [7:0] opcode = '0;
  logic [3:0] flags = '0;
  logic dec_valid, mem_operand, cond_met, illegal;
  logic [3:0] dec_class;
  logic [2:0] src_reg, dst_reg, alu_op, cond_code;
  logic [1:0] inst_len;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opcode_field_decoder uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .flags(flags),
    .dec_valid(dec_valid), .dec_class(dec_class), .src_reg(src_reg), .dst_reg(dst_reg),
    .alu_op(alu_op), .cond_code(cond_code), .inst_len(inst_len),
    .mem_operand(mem_operand), .cond_met(cond_met), .illegal(illegal)
  );

  // packed: class(4) src(3) dst(3) alu(3) cond(3) len(2) mem met ill = 21 bits
  function automatic logic [20:0] expect_of(input logic [7:0] op, input logic [3:0] fl);
    logic [3:0] c = 0; logic [2:0] s = 0, d = 0, a = 0, k = 0;
    logic [1:0] n = 1; logic m = 0, t = 0, il = 0;
    logic [2:0] f53 = op[5:3], f20 = op[2:0];
    bit fv;
    case (f53 % 4)
      0: fv = fl[0]; 1: fv = fl[1]; 2: fv = fl[2]; default: fv = fl[3];
    endcase
    casez (op)
      8'h00, 8'h01, 8'hFF: c = 1;
      8'hC0: c = 0;
      8'b11??????: begin c = 2; s = f20; d = f53; m = (s == 7) || (d == 7); end
      8'b10??????: begin c = 3; s = f20; a = f53; m = (s == 7); end
      8'b01???000: begin c = 6; k = f53; n = 3; t = ((f53 >= 4) == fv); end
      8'b01???010: begin c = 7; k = f53; n = 3; t = ((f53 >= 4) == fv); end
      8'b01???100: begin c = 6; n = 3; t = 1; end
      8'b01???110: begin c = 7; n = 3; t = 1; end
      8'b00???011: begin c = 8; k = f53; t = ((f53 >= 4) == fv); end
      8'b00???111: begin c = 8; t = 1; end
      8'b00???100: begin c = 4; a = f53; n = 2; end
      8'b00???110: begin c = 5; d = f53; n = 2; m = (d == 7); end
      8'h02, 8'h0A: c = 9;
      default: il = 1;
    endcase
    return {c, s, d, a, k, n, m, t, il};
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    casez (op)
      8'h00, 8'h01, 8'hFF: return "R3";
      8'hC0: return "R4";
      8'b11??????: return "R5/R7";
      8'b10??????: return "R6/R7";
      8'b01???000, 8'b01???010: return "R9/R11";
      8'b01???100, 8'b01???110: return "R9";
      8'b00???011, 8'b00???111: return "R10/R11";
      8'b00???100, 8'b00???110: return "R8/R7";
      8'h02, 8'h0A: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic logic [20:0] actual();
    return {dec_class, src_reg, dst_reg, alu_op, cond_code, inst_len, mem_operand, cond_met, illegal};
  endfunction

  task automatic check(input string req, input logic [20:0] act, input logic [20:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [3:0] fl);
    @(negedge clk);
    op_valid = 1'b1; opcode = op; flags = fl;
    @(negedge clk);
    op_valid = 1'b0;
    check({tag_of(op), " op=", $sformatf("%h", op)}, actual(), expect_of(op, fl));
    check("R2 valid", {20'd0, dec_valid}, 21'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [20:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", actual(), 21'd0);
    check("R1 reset valid", {20'd0, dec_valid}, 21'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {actual()[20:1] , dec_valid}, 21'd0);

    // overrides against the move pattern, random flags
    apply(8'hFF, 4'hF); apply(8'hC0, 4'h5); apply(8'h00, 4'h0); apply(8'h01, 4'hA);
    apply(8'hC7, 4'h0); apply(8'hF8, 4'h0); apply(8'h3E, 4'h0); apply(8'h02, 4'h3);

    // every opcode once
    for (int i = 0; i < 256; i++) apply(i[7:0], 4'($urandom));

    // condition sweep
    for (int cc = 0; cc < 8; cc++)
      for (int fl = 0; fl < 16; fl++) begin
        apply({2'b01, cc[2:0], 3'b000}, fl[3:0]);
        apply({2'b00, cc[2:0], 3'b011}, fl[3:0]);
      end

    // hold while idle (R2)
    apply(8'h87, 4'h0);
    held = actual();
    @(negedge clk);
    opcode = 8'h44; flags = 4'hF;
    @(negedge clk);
    check("R2 hold fields", actual(), held);
    check("R2 idle valid", {20'd0, dec_valid}, 21'd0);

    // random mix
    repeat (300) apply(8'($urandom), 4'($urandom));

    finish_run();
  end
endmodule